// File: doc/BRIEF.md
# Nameless Result Writeback Controller

This block sits beside one function unit and decides what becomes of the result that the unit produces. It can write the result to the register file, or it can drop the result. A unit becomes "nameless" when a younger instruction that targets the same destination register is issued while this unit is still computing. Once nameless, the unit does not write back. It keeps the result in its destination latch so that dependent instructions can pick it up as a forwarded operand.

The latched value is safe to throw away only when two things are true for every dependent consumer. The consumer must have taken the operand, and it must be past the point where it could still raise an exception. If a consumer is killed (the die signal), the overwriting instruction is rolled back. The unit then becomes named again and must commit its value to the register file.

Up to `NUM_DEP` consumer slots are tracked with one bit each. Each slot has separate strobes for attach, read and exception-clear. Issue logic, the ALU and the register file are outside this block.

Top module: `nameless_wb_ctrl`

## Requirements
- R1: After reset, `unitBusy`, `wbReq` and `resultDrop` are all 0.
- R2: `issueValid` while idle makes `unitBusy` 1 from the next cycle. `issueValid` while busy is ignored, and the outputs continue exactly as if it had been 0.
- R3: A result (`resultValid` while executing) on a unit that is not nameless raises `wbReq` in the next cycle, with `wbData` equal to the captured `resultData`.
- R4: `wbReq` stays 1 until a cycle with `wbAck` = 1. After that cycle, `wbReq` is 0 and the unit is idle.
- R5: `overwrite` while executing marks the unit nameless. A nameless unit's result never raises `wbReq` unless a later die reverts it. `overwrite` outside execution is ignored.
- R6: From the cycle after capture, until the unit goes idle, `fwdData` shows the captured result.
- R7: A nameless unit holding its result asserts `resultDrop` in the very cycle that the last attached slot has both its read and its exception-clear flag. Flags may arrive in that cycle or in any earlier cycle since issue. The unit is idle in the next cycle. A nameless unit with no attached slot drops in its first holding cycle.
- R8: A slot that has read but not cleared, or cleared but not read, keeps `resultDrop` at 0.
- R9: `die` while a nameless unit holds its result suppresses the drop and raises `wbReq` in the next cycle.
- R10: When `die` and the final exception-clear arrive in the same cycle, `die` wins: `resultDrop` stays 0 and a writeback follows.
- R11: `die` while executing clears the nameless mark, and it takes priority over an `overwrite` in the same cycle. The result is then written back.
- R12: `resultDrop` is a single-cycle pulse and is never 1 together with `wbReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | New instruction assigned to this unit |
| overwrite | input | 1 | Younger instruction claims the same destination register |
| resultValid | input | 1 | ALU result available this cycle |
| resultData | input | DATA_W | ALU result value |
| depAttach | input | NUM_DEP | Slot becomes a consumer of this result |
| depRead | input | NUM_DEP | Slot has taken the forwarded operand |
| depClear | input | NUM_DEP | Slot is past its exception point |
| die | input | 1 | A dependent was killed; roll back the overwrite |
| wbAck | input | 1 | Register file accepted the write |
| unitBusy | output | 1 | Unit is not idle |
| wbReq | output | 1 | Register-file write request |
| wbData | output | DATA_W | Data for the write |
| fwdData | output | DATA_W | Destination latch for forwarding |
| resultDrop | output | 1 | Result discarded; unit freed |

## Verification
The bench targets several corner cases.

- Die and final clear in the same cycle: a design that ranked these the wrong way would drop a value whose rollback still needs it.
- A slot that has read but never cleared, or cleared but never read: logic that tested only one flag would release early.
- A nameless unit with no consumers: a design that waited for a consumer here would hang.
- A die while still executing, and a held writeback with `wbAck` low for several cycles: a wrong design would lose the value or drop the request.
- Issues that arrive while busy: a design that honoured them would clear the consumer masks in mid-flight.

A long random phase drives every input and compares all outputs on every cycle against a behavioural model.

// File: rtl/nwb_pkg.sv
package nwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EXEC  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_WRITE = 2'd3
  } nwbState_e;

  typedef struct packed {
    logic capture;    // latch the ALU result
    logic clearDeps;  // forget all consumer bookkeeping
  } nwbStrobe_t;
endpackage

// File: rtl/nwb_datapath.sv
module nwb_datapath
  import nwb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_DEP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  nwbStrobe_t         strobe,
  input  logic [DATA_W-1:0]  resultData,
  input  logic [NUM_DEP-1:0] depAttach,
  input  logic [NUM_DEP-1:0] depRead,
  input  logic [NUM_DEP-1:0] depClear,
  output logic [DATA_W-1:0]  latchData,
  output logic               depsSettled
);
  logic [NUM_DEP-1:0] attachMask, readMask, clearMask;
  logic [NUM_DEP-1:0] attachNow, readNow, clearNow;
  logic [NUM_DEP-1:0] slotPending;

  assign attachNow = attachMask | depAttach;
  assign readNow   = readMask   | depRead;
  assign clearNow  = clearMask  | depClear;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchData <= '0;
    end else if (strobe.capture) begin
      latchData <= resultData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearDeps) begin
      attachMask <= '0;
      readMask   <= '0;
      clearMask  <= '0;
    end else begin
      attachMask <= attachNow;
      readMask   <= readNow;
      clearMask  <= clearNow;
    end
  end

  // a slot is outstanding until it has both taken the value and cleared
  for (genvar slot = 0; slot < NUM_DEP; slot++) begin : gSlot
    assign slotPending[slot] = attachNow[slot] & ~(readNow[slot] & clearNow[slot]);
  end

  assign depsSettled = ~|slotPending;

  AST_SETTLED_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (depsSettled && !strobe.clearDeps) |-> ((attachNow & ~readNow) == '0)) else $error("R8"); // R8
endmodule

// File: rtl/nwb_control.sv
module nwb_control
  import nwb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueValid,
  input  logic       overwrite,
  input  logic       resultValid,
  input  logic       die,
  input  logic       wbAck,
  input  logic       depsSettled,
  output nwbStrobe_t strobe,
  output logic       unitBusy,
  output logic       wbReq,
  output logic       resultDrop
);
  nwbState_e state, stateNext;
  logic      nameless, namelessEff;

  // die rolls back the overwrite, and wins over a same-cycle overwrite
  assign namelessEff = die ? 1'b0 : (overwrite ? 1'b1 : nameless);

  assign strobe.clearDeps = (state == ST_IDLE) && issueValid;
  assign strobe.capture   = (state == ST_EXEC) && resultValid;

  assign unitBusy   = (state != ST_IDLE);
  assign wbReq      = (state == ST_WRITE);
  assign resultDrop = (state == ST_HOLD) && !die && depsSettled;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (issueValid) stateNext = ST_EXEC;
      ST_EXEC:  if (resultValid) stateNext = namelessEff ? ST_HOLD : ST_WRITE;
      ST_HOLD: begin
        if (die)              stateNext = ST_WRITE;
        else if (depsSettled) stateNext = ST_IDLE;
      end
      ST_WRITE: if (wbAck) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      nameless <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE)      nameless <= 1'b0;
      else if (state == ST_EXEC) nameless <= namelessEff;
    end
  end

  AST_WB_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck) |=> wbReq) else $error("R4"); // R4
  AST_WB_ACK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && wbAck) |=> !unitBusy) else $error("R4"); // R4
  AST_DROP_NOT_DIE: assert property (@(posedge clk) disable iff (!rstN)
    resultDrop |-> !die) else $error("R10"); // R10
  AST_DROP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(resultDrop && wbReq)) else $error("R12"); // R12
  AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resultDrop |=> (!resultDrop && !unitBusy)) else $error("R7"); // R7
  AST_DIE_HOLD_WB: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_HOLD) && die) |=> wbReq) else $error("R9"); // R9
endmodule

// File: rtl/nameless_wb_ctrl.sv
module nameless_wb_ctrl
  import nwb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_DEP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic               overwrite,
  input  logic               resultValid,
  input  logic [DATA_W-1:0]  resultData,
  input  logic [NUM_DEP-1:0] depAttach,
  input  logic [NUM_DEP-1:0] depRead,
  input  logic [NUM_DEP-1:0] depClear,
  input  logic               die,
  input  logic               wbAck,
  output logic               unitBusy,
  output logic               wbReq,
  output logic [DATA_W-1:0]  wbData,
  output logic [DATA_W-1:0]  fwdData,
  output logic               resultDrop
);
  nwbStrobe_t        strobe;
  logic              depsSettled;
  logic [DATA_W-1:0] latchData;

  nwb_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .issueValid  (issueValid),
    .overwrite   (overwrite),
    .resultValid (resultValid),
    .die         (die),
    .wbAck       (wbAck),
    .depsSettled (depsSettled),
    .strobe      (strobe),
    .unitBusy    (unitBusy),
    .wbReq       (wbReq),
    .resultDrop  (resultDrop)
  );

  nwb_datapath #(.DATA_W(DATA_W), .NUM_DEP(NUM_DEP)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .resultData  (resultData),
    .depAttach   (depAttach),
    .depRead     (depRead),
    .depClear    (depClear),
    .latchData   (latchData),
    .depsSettled (depsSettled)
  );

  assign wbData  = latchData;
  assign fwdData = latchData;
endmodule

// File: tb/test_nameless_wb_ctrl.sv
module test_nameless_wb_ctrl;
  localparam int DW = 32;
  localparam int ND = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 0, overwrite = 0, resultValid = 0, die = 0, wbAck = 0;
  logic [DW-1:0] resultData = '0;
  logic [ND-1:0] depAttach = '0, depRead = '0, depClear = '0;
  logic unitBusy, wbReq, resultDrop;
  logic [DW-1:0] wbData, fwdData;

  int checks = 0;
  int errors = 0;

  // behavioural reference: 0 idle, 1 executing, 2 holding nameless, 3 writing
  int mState = 0;
  bit mNameless = 0;
  bit [ND-1:0] mAtt = '0, mRd = '0, mClr = '0;
  bit [DW-1:0] mData = '0;

  always #5 clk = ~clk;

  nameless_wb_ctrl #(.DATA_W(DW), .NUM_DEP(ND)) i_nameless_wb_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .overwrite(overwrite),
    .resultValid(resultValid), .resultData(resultData), .depAttach(depAttach),
    .depRead(depRead), .depClear(depClear), .die(die), .wbAck(wbAck),
    .unitBusy(unitBusy), .wbReq(wbReq), .wbData(wbData), .fwdData(fwdData),
    .resultDrop(resultDrop)
  );

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic clearIn();
    issueValid = 0; overwrite = 0; resultValid = 0; die = 0; wbAck = 0;
    depAttach = '0; depRead = '0; depClear = '0;
  endtask

  // inputs are set at the falling edge; compare, clock, advance the model
  task automatic step(input string tag);
    bit expDrop, nl;
    #1;
    expDrop = (mState == 2) && !die &&
              (((mAtt | depAttach) & ~((mRd | depRead) & (mClr | depClear))) == '0);
    chk(tag, "unitBusy", unitBusy, mState != 0);
    chk(tag, "wbReq", wbReq, mState == 3);
    chk(tag, "resultDrop", resultDrop, expDrop);
    if (mState == 3) chk(tag, "wbData", wbData, mData);
    if (mState >= 2) chk(tag, "fwdData", fwdData, mData);
    @(posedge clk);
    nl = die ? 1'b0 : (overwrite ? 1'b1 : mNameless);
    if (mState == 0 && issueValid) begin
      mAtt = '0; mRd = '0; mClr = '0;
    end else begin
      mAtt |= depAttach; mRd |= depRead; mClr |= depClear;
    end
    case (mState)
      0: begin mNameless = 0; if (issueValid) mState = 1; end
      1: begin
        mNameless = nl;
        if (resultValid) begin mData = resultData; mState = nl ? 2 : 3; end
      end
      2: if (die) mState = 3; else if (expDrop) mState = 0;
      3: if (wbAck) mState = 0;
      default: mState = 0;
    endcase
    @(negedge clk);
    clearIn();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "unitBusy", unitBusy, 0);
    chk("R1", "wbReq", wbReq, 0);
    chk("R1", "resultDrop", resultDrop, 0);
    rstN = 1;

    // R3 / R4: named path, ack delayed; R2: issue while busy ignored
    issueValid = 1; step("R2");
    issueValid = 1; step("R2");
    resultValid = 1; resultData = 32'hA5A5_0001; step("R3");
    issueValid = 1; step("R4");
    step("R4");
    wbAck = 1; step("R4");
    step("R4");

    // R5: overwrite outside execution is ignored (unit idle)
    overwrite = 1; step("R5");

    // R7 / R8: nameless with slots 0 and 3
    issueValid = 1; step("R7");
    overwrite = 1; depAttach = 8'h09; step("R5");
    resultValid = 1; resultData = 32'h1234_5678; step("R6");
    depRead = 8'h01; depClear = 8'h01; step("R8");
    depRead = 8'h08; step("R8");
    step("R6");
    depClear = 8'h08; step("R7");
    step("R7");

    // R8: clear without read keeps it
    issueValid = 1; step("R8");
    overwrite = 1; resultValid = 1; resultData = 32'h0BAD_F00D; depAttach = 8'h80; step("R8");
    depClear = 8'h80; step("R8");
    step("R8");
    depRead = 8'h80; step("R7");

    // R9: die while holding
    issueValid = 1; step("R9");
    overwrite = 1; depAttach = 8'h02; step("R9");
    resultValid = 1; resultData = 32'hDEAD_0009; step("R9");
    die = 1; depRead = 8'h02; step("R9");
    step("R9");
    wbAck = 1; step("R9");

    // R10: die with final clear in the same cycle
    issueValid = 1; step("R10");
    overwrite = 1; depAttach = 8'h04; depRead = 8'h04; step("R10");
    resultValid = 1; resultData = 32'hCAFE_0010; step("R10");
    die = 1; depClear = 8'h04; step("R10");
    wbAck = 1; step("R10");

    // R11: die while executing reverts, and beats overwrite
    issueValid = 1; step("R11");
    overwrite = 1; step("R11");
    die = 1; overwrite = 1; step("R11");
    resultValid = 1; resultData = 32'h0000_0011; step("R11");
    wbAck = 1; step("R11");

    // R7: nameless with no consumers drops at once
    issueValid = 1; step("R7");
    overwrite = 1; resultValid = 1; resultData = 32'h7777_0007; step("R7");
    step("R7");
    step("R12");

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      issueValid  = ($urandom_range(0, 3) == 0);
      overwrite   = ($urandom_range(0, 3) == 0);
      resultValid = ($urandom_range(0, 3) == 0);
      resultData  = $urandom;
      die         = ($urandom_range(0, 9) == 0);
      wbAck       = ($urandom_range(0, 2) == 0);
      depAttach   = ($urandom_range(0, 2) == 0) ? ND'(1 << $urandom_range(0, ND - 1)) : '0;
      depRead     = ND'($urandom) & ND'($urandom);
      depClear    = ND'($urandom) & ND'($urandom);
      step("R12");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule